// File: doc/BRIEF.md
# Three-wire serial EEPROM slave

This block is a synthesizable behavioural model of a small serial EEPROM that a host reaches through four pins: a chip select, a shift clock, a serial data input and a serial data output. All pins are sampled on the system clock, so the shift clock is treated as a synchronous input whose rising edges are detected internally. The array holds 256 bytes. A static organisation input selects whether the array is seen as 256 bytes or as 128 words of 16 bits.

The host raises chip select, then clocks in a start bit, a two-bit opcode, an address field and, for the data-carrying commands, a data field. Reads stream data back on the output. A read can continue through consecutive locations for as long as chip select stays high. Commands that change the array are blocked until programming has been enabled. An accepted programming command starts a self-timed cycle whose length is a parameter in system clock cycles. The host can poll the end of that cycle by toggling chip select and watching the output.

Top module: `eep3w_slave`

## Requirements
- R1: An instruction starts with the first `di` bit sampled high on a rising `sk` edge after `cs` rises. Next comes a 2-bit opcode, MSB first: 10 read, 01 write, 11 erase, 00 group. The address field is 9 bits in byte mode (`org16`=0) and 8 bits in word mode (`org16`=1), MSB first. Its top bit is don't-care but must be clocked.
- R2: After the last address bit of a read, `dout` drives a single 0 dummy bit. It then drives the addressed word MSB first, 8 bits in byte mode and 16 in word mode. Each bit appears in the clock cycle after the `sk` rising edge is sampled.
- R3: While `cs` stays high after a read word, the next location follows immediately with no dummy bit. The location pointer wraps from the last location to 0.
- R4: After reset, programming is disabled. In this state erase, write, erase-all and write-all leave the array unchanged and start no busy cycle. In the group opcode, the top two address-field bits 11 enable programming and 00 disable it again.
- R5: A read returns the array contents whether programming is enabled or not.
- R6: Erase (opcode 11) sets the addressed location to all ones. Erase-all (group code 10) sets every byte to 0xFF. A write replaces the old value without a prior erase.
- R7: Write-all (group code 01, followed by a data field) stores the data field in every location of the current organisation.
- R8: An accepted programming command keeps the block busy for exactly PROG_CYCLES cycles after the clock edge that samples its last bit. If `cs` goes low and then high while busy, `dout_oe` is 1 and `dout` shows 0 while busy and 1 once ready.
- R9: If `cs` rises only after the programming cycle has ended, `dout_oe` stays 0.
- R10: `dout_oe` is 0 whenever `cs` is low, including after reset.
- R11: An instruction whose start bit arrives while the block is busy is ignored entirely, even if busy ends during the frame.
- R12: Reset fills the array with 0xFF. In word mode, word w holds byte 2w+1 as its upper 8 bits and byte 2w as its lower 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial shift clock, sampled on clk |
| di | input | 1 | Serial data input |
| org16 | input | 1 | Organisation: 1 = 16-bit words, 0 = bytes |
| dout | output | 1 | Serial data output |
| dout_oe | output | 1 | Output enable for dout (0 = high impedance) |

## Verification
The bench keeps the default 256-byte array, so the pointer wrap can be reached in both organisations: at byte 255 and at word 127. It sets PROG_CYCLES to 40, which is shorter than one write frame. With that value a second instruction can begin while the block is busy and have busy end partway through its frame. The exact busy length can also be probed: the output is checked one cycle before the expected ready edge and again on it.

// File: rtl/eep3w_pkg.sv
package eep3w_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 16;

  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_ERASE = 2'b11;
  localparam logic [1:0] OPC_GROUP = 2'b00;

  localparam logic [1:0] SUB_PEN  = 2'b11;
  localparam logic [1:0] SUB_PDIS = 2'b00;
  localparam logic [1:0] SUB_CLRA = 2'b10;
  localparam logic [1:0] SUB_FILA = 2'b01;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_PEN,
    OP_PDIS,
    OP_ERASE,
    OP_WRITE,
    OP_CLRA,
    OP_FILA
  } prog_op_e;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_OPC,
    FS_ADR,
    FS_DAT,
    FS_RD,
    FS_HOLD
  } fe_state_e;

endpackage

// File: rtl/eep3w_rst_sync.sv
module eep3w_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/eep3w_edge.sv
module eep3w_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  output logic sk_rise,
  output logic cs_rise
);
  logic cs_q;
  logic sk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b0;
      sk_q <= 1'b0;
    end else begin
      cs_q <= cs;
      sk_q <= sk;
    end
  end

  assign sk_rise = cs & sk & ~sk_q;
  assign cs_rise = cs & ~cs_q;
endmodule

// File: rtl/eep3w_frontend.sv
module eep3w_frontend
  import eep3w_pkg::*;
#(
  parameter int unsigned BA = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs,
  input  logic                di,
  input  logic                org16,
  input  logic                sk_rise,
  input  logic                cs_rise,
  input  logic                busy,
  input  logic [WORD_W-1:0]   rd_data,
  output logic [BA-1:0]       rd_idx,
  output prog_op_e            cmd_op,
  output logic [BA-1:0]       cmd_idx,
  output logic [WORD_W-1:0]   cmd_data,
  output logic                dout,
  output logic                dout_oe
);
  localparam int unsigned FA8  = BA + 1;
  localparam int unsigned FA16 = BA;
  localparam int unsigned SHW  = (FA8 > WORD_W) ? FA8 : WORD_W;
  localparam int unsigned CW   = $clog2(SHW + 1);

  fe_state_e         state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [1:0]        opc_q, opc_d;
  logic [SHW-1:0]    sh_q, sh_d;
  logic [BA-1:0]     ptr_q, ptr_d;
  logic [WORD_W-1:0] rsh_q, rsh_d;
  logic              rbit_q, rbit_d;
  logic              stat_q, stat_d;

  logic [SHW-1:0]    sh_nx;
  logic [BA-1:0]     addr_nx;
  logic [BA-1:0]     ptr_inc;
  logic [1:0]        sub_nx;
  logic [CW-1:0]     fa_last;
  logic [CW-1:0]     dw_last;
  logic [BA-2:0]     wrd_inc;

  always_comb begin
    sh_nx   = {sh_q[SHW-2:0], di};
    addr_nx = org16 ? {1'b0, sh_nx[BA-2:0]} : sh_nx[BA-1:0];
    sub_nx  = org16 ? sh_nx[FA16-1 -: 2] : sh_nx[FA8-1 -: 2];
    wrd_inc = ptr_q[BA-2:0] + (BA-1)'(1);
    ptr_inc = org16 ? {1'b0, wrd_inc} : ptr_q + BA'(1);
    fa_last = org16 ? CW'(FA16 - 1) : CW'(FA8 - 1);
    dw_last = org16 ? CW'(WORD_W - 1) : CW'(BYTE_W - 1);
    rd_idx  = (state_q == FS_ADR) ? addr_nx : ptr_inc;
  end

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    opc_d    = opc_q;
    sh_d     = sh_q;
    ptr_d    = ptr_q;
    rsh_d    = rsh_q;
    rbit_d   = rbit_q;
    stat_d   = stat_q;
    cmd_op   = OP_NONE;
    cmd_idx  = ptr_q;
    cmd_data = org16 ? sh_nx[WORD_W-1:0] : {{BYTE_W{1'b0}}, sh_nx[BYTE_W-1:0]};

    if (!cs) begin
      state_d = FS_IDLE;
      stat_d  = 1'b0;
    end else begin
      if (cs_rise && busy) begin
        stat_d = 1'b1;
      end
      if (sk_rise) begin
        case (state_q)
          FS_IDLE: begin
            if (busy) begin
              state_d = FS_HOLD;
            end else if (di) begin
              state_d = FS_OPC;
              cnt_d   = '0;
              stat_d  = 1'b0;
            end
          end
          FS_OPC: begin
            opc_d = {opc_q[0], di};
            if (cnt_q == CW'(1)) begin
              state_d = FS_ADR;
              cnt_d   = '0;
              sh_d    = '0;
            end else begin
              cnt_d = cnt_q + CW'(1);
            end
          end
          FS_ADR: begin
            sh_d  = sh_nx;
            cnt_d = cnt_q + CW'(1);
            if (cnt_q == fa_last) begin
              ptr_d = addr_nx;
              cnt_d = '0;
              sh_d  = '0;
              case (opc_q)
                OPC_READ: begin
                  state_d = FS_RD;
                  rsh_d   = rd_data;
                  rbit_d  = 1'b0;
                end
                OPC_WRITE: state_d = FS_DAT;
                OPC_ERASE: begin
                  cmd_op  = OP_ERASE;
                  cmd_idx = addr_nx;
                  state_d = FS_HOLD;
                end
                default: begin
                  state_d = FS_HOLD;
                  case (sub_nx)
                    SUB_PEN:  cmd_op = OP_PEN;
                    SUB_PDIS: cmd_op = OP_PDIS;
                    SUB_CLRA: cmd_op = OP_CLRA;
                    default:  state_d = FS_DAT;
                  endcase
                end
              endcase
            end
          end
          FS_DAT: begin
            sh_d = sh_nx;
            if (cnt_q == dw_last) begin
              cmd_op  = (opc_q == OPC_WRITE) ? OP_WRITE : OP_FILA;
              state_d = FS_HOLD;
            end else begin
              cnt_d = cnt_q + CW'(1);
            end
          end
          FS_RD: begin
            rbit_d = rsh_q[WORD_W-1];
            if (cnt_q == dw_last) begin
              cnt_d = '0;
              ptr_d = ptr_inc;
              rsh_d = rd_data;
            end else begin
              cnt_d = cnt_q + CW'(1);
              rsh_d = {rsh_q[WORD_W-2:0], 1'b0};
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      cnt_q   <= '0;
      opc_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      rsh_q   <= '0;
      rbit_q  <= 1'b0;
      stat_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      stat_q  <= stat_d;
      if (sk_rise) begin
        cnt_q  <= cnt_d;
        opc_q  <= opc_d;
        sh_q   <= sh_d;
        ptr_q  <= ptr_d;
        rsh_q  <= rsh_d;
        rbit_q <= rbit_d;
      end
    end
  end

  assign dout    = stat_q ? ~busy : rbit_q;
  assign dout_oe = cs & (stat_q | (state_q == FS_RD));
endmodule

// File: rtl/eep3w_store.sv
module eep3w_store
  import eep3w_pkg::*;
#(
  parameter int unsigned DEPTH       = 256,
  parameter int unsigned PROG_CYCLES = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   org16,
  input  prog_op_e               cmd_op,
  input  logic [$clog2(DEPTH)-1:0] cmd_idx,
  input  logic [WORD_W-1:0]      cmd_data,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [WORD_W-1:0]      rd_data,
  output logic                   busy,
  output logic                   prog_en
);
  localparam int unsigned BA = $clog2(DEPTH);
  localparam int unsigned TW = $clog2(PROG_CYCLES + 1);

  logic [DEPTH*BYTE_W-1:0] flat;
  logic                    en_q, en_d;
  logic                    busy_q, busy_d;
  logic [TW-1:0]           tmr_q, tmr_d;
  logic                    is_prog, go, all_loc;
  logic [WORD_W-1:0]       wval;

  always_comb begin
    is_prog = (cmd_op == OP_ERASE) || (cmd_op == OP_WRITE) ||
              (cmd_op == OP_CLRA)  || (cmd_op == OP_FILA);
    go      = is_prog && en_q && !busy_q;
    all_loc = (cmd_op == OP_CLRA) || (cmd_op == OP_FILA);
    wval    = ((cmd_op == OP_ERASE) || (cmd_op == OP_CLRA)) ? {WORD_W{1'b1}} : cmd_data;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    localparam logic [BA-1:0] GI = BA'(g);
    logic [BYTE_W-1:0] cell_q;
    logic              hit;
    logic [BYTE_W-1:0] bval;

    always_comb begin
      hit  = all_loc || (org16 ? (cmd_idx[BA-2:0] == GI[BA-1:1]) : (cmd_idx == GI));
      bval = (org16 && GI[0]) ? wval[WORD_W-1:BYTE_W] : wval[BYTE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q <= {BYTE_W{1'b1}};
      end else if (go && hit) begin
        cell_q <= bval;
      end
    end

    assign flat[g*BYTE_W +: BYTE_W] = cell_q;
  end

  always_comb begin
    if (org16) begin
      rd_data = flat[int'(rd_idx[BA-2:0])*WORD_W +: WORD_W];
    end else begin
      rd_data = {flat[int'(rd_idx)*BYTE_W +: BYTE_W], {BYTE_W{1'b0}}};
    end
  end

  always_comb begin
    en_d   = en_q;
    busy_d = busy_q;
    tmr_d  = tmr_q;
    if (!busy_q && cmd_op == OP_PEN)  en_d = 1'b1;
    if (!busy_q && cmd_op == OP_PDIS) en_d = 1'b0;
    if (go) begin
      busy_d = 1'b1;
      tmr_d  = TW'(PROG_CYCLES - 1);
    end else if (busy_q) begin
      if (tmr_q == '0) begin
        busy_d = 1'b0;
      end else begin
        tmr_d = tmr_q - TW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      busy_q <= 1'b0;
      tmr_q  <= '0;
    end else begin
      en_q   <= en_d;
      busy_q <= busy_d;
      tmr_q  <= tmr_d;
    end
  end

  assign busy    = busy_q;
  assign prog_en = en_q;
endmodule

// File: rtl/eep3w_slave.sv
module eep3w_slave
  import eep3w_pkg::*;
#(
  parameter int unsigned DEPTH       = 256,
  parameter int unsigned PROG_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  input  logic org16,
  output logic dout,
  output logic dout_oe
);
  localparam int unsigned BA = $clog2(DEPTH);

  logic              rst_s;
  logic              sk_rise;
  logic              cs_rise;
  logic              prog_busy;
  logic              prog_en;
  prog_op_e          cmd_op;
  logic [BA-1:0]     cmd_idx;
  logic [WORD_W-1:0] cmd_data;
  logic [BA-1:0]     rd_idx;
  logic [WORD_W-1:0] rd_data;

  eep3w_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_s)
  );

  eep3w_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_s),
    .cs      (cs),
    .sk      (sk),
    .sk_rise (sk_rise),
    .cs_rise (cs_rise)
  );

  eep3w_frontend #(.BA(BA)) u_fe (
    .clk      (clk),
    .rst_n    (rst_s),
    .cs       (cs),
    .di       (di),
    .org16    (org16),
    .sk_rise  (sk_rise),
    .cs_rise  (cs_rise),
    .busy     (prog_busy),
    .rd_data  (rd_data),
    .rd_idx   (rd_idx),
    .cmd_op   (cmd_op),
    .cmd_idx  (cmd_idx),
    .cmd_data (cmd_data),
    .dout     (dout),
    .dout_oe  (dout_oe)
  );

  eep3w_store #(.DEPTH(DEPTH), .PROG_CYCLES(PROG_CYCLES)) u_store (
    .clk      (clk),
    .rst_n    (rst_s),
    .org16    (org16),
    .cmd_op   (cmd_op),
    .cmd_idx  (cmd_idx),
    .cmd_data (cmd_data),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .busy     (prog_busy),
    .prog_en  (prog_en)
  );
endmodule

// File: rtl/eep3w_slave_chk.sv
module eep3w_slave_chk
  import eep3w_pkg::*;
#(
  parameter int unsigned PROG_CYCLES = 64
) (
  input logic     clk,
  input logic     rst_n,
  input logic     cs,
  input logic     dout,
  input logic     dout_oe,
  input logic     busy,
  input logic     wr_en,
  input prog_op_e cmd_op
);
  logic [31:0] blen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blen_q <= '0;
    end else if (busy) begin
      blen_q <= blen_q + 32'd1;
    end else begin
      blen_q <= '0;
    end
  end

  p_hiz_deselected_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> !dout_oe);

  p_status_low_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && busy) |-> !dout);

  p_busy_length_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (blen_q == PROG_CYCLES));

  p_no_cmd_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op != OP_NONE) |-> !busy);

  p_prog_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en));

  p_en_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en) |-> $past(cmd_op == OP_PEN));
endmodule

bind eep3w_slave eep3w_slave_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk     (clk),
  .rst_n   (rst_s),
  .cs      (cs),
  .dout    (dout),
  .dout_oe (dout_oe),
  .busy    (prog_busy),
  .wr_en   (prog_en),
  .cmd_op  (cmd_op)
);

// File: tb/tb_eep3w_slave.sv
`timescale 1ns/1ps
module tb_eep3w_slave;
  localparam int PROG  = 40;
  localparam int DEPTH = 256;

  logic clk = 1'b0;
  logic rst_n, cs, sk, di, org16;
  logic dout, dout_oe;

  always #2 clk = ~clk;

  eep3w_slave #(.DEPTH(DEPTH), .PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .org16(org16),
    .dout(dout), .dout_oe(dout_oe)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [7:0] ref_mem [DEPTH];
  bit ref_en;

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bit(logic b);
    di = b; sk = 1'b0; tick(2);
    sk = 1'b1; tick(2);
  endtask

  task automatic send_val(logic [15:0] v, int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic close_frame();
    sk = 1'b0; cs = 1'b0; tick(2);
  endtask

  function automatic int fa(bit o);
    return o ? 8 : 9;
  endfunction

  function automatic logic [15:0] afield(bit o, int a);
    logic dc;
    dc = 1'($urandom_range(0, 1));
    return o ? {8'h00, dc, 7'(a)} : {7'h00, dc, 8'(a)};
  endfunction

  task automatic header(bit o, logic [1:0] opc, logic [15:0] field);
    org16 = o; cs = 1'b1; tick(2);
    send_bit(1'b1);
    send_val({14'b0, opc}, 2);
    send_val(field, fa(o));
  endtask

  task automatic group(bit o, logic [1:0] sub);
    header(o, 2'b00, o ? {8'h00, sub, 6'h00} : {7'h00, sub, 7'h00});
  endtask

  function automatic logic [15:0] exp_word(bit o, int a);
    int m;
    m = o ? (a % (DEPTH / 2)) : (a % DEPTH);
    return o ? {ref_mem[2*m+1], ref_mem[2*m]} : {8'h00, ref_mem[m]};
  endfunction

  task automatic ref_store(bit o, int a, logic [15:0] d);
    if (!ref_en) return;
    if (o) begin
      ref_mem[2*a+1] = d[15:8];
      ref_mem[2*a]   = d[7:0];
    end else begin
      ref_mem[a] = d[7:0];
    end
  endtask

  task automatic raw_write(bit o, int a, logic [15:0] d);
    header(o, 2'b01, afield(o, a));
    send_val(d, o ? 16 : 8);
  endtask

  task automatic do_write(bit o, int a, logic [15:0] d);
    raw_write(o, a, d);
    close_frame();
    ref_store(o, a, d);
    tick(PROG + 4);
  endtask

  task automatic do_erase(bit o, int a);
    header(o, 2'b11, afield(o, a));
    close_frame();
    ref_store(o, a, 16'hFFFF);
    tick(PROG + 4);
  endtask

  task automatic do_pen(bit o);
    group(o, 2'b11); close_frame(); ref_en = 1;
  endtask

  task automatic do_pdis(bit o);
    group(o, 2'b00); close_frame(); ref_en = 0;
  endtask

  task automatic do_clra(bit o);
    group(o, 2'b10); close_frame();
    if (ref_en) for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
    tick(PROG + 4);
  endtask

  task automatic do_fila(bit o, logic [15:0] d);
    group(o, 2'b01);
    send_val(d, o ? 16 : 8);
    close_frame();
    if (ref_en) for (int i = 0; i < DEPTH; i++)
      ref_mem[i] = o ? ((i % 2 == 1) ? d[15:8] : d[7:0]) : d[7:0];
    tick(PROG + 4);
  endtask

  task automatic do_read(bit o, int a, int n, string req);
    logic [15:0] w;
    header(o, 2'b10, afield(o, a));
    check({req, " dummy R2"}, {14'b0, dout_oe, dout}, 16'h0002);
    for (int k = 0; k < n; k++) begin
      w = '0;
      for (int b = 0; b < (o ? 16 : 8); b++) begin
        sk = 1'b0; tick(2); sk = 1'b1; tick(2);
        w = {w[14:0], dout};
      end
      check(k == 0 ? req : {req, " next R3"}, w, exp_word(o, a + k));
    end
    close_frame();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
    ref_en = 0;
    rst_n = 1'b0; cs = 1'b0; sk = 1'b0; di = 1'b0; org16 = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(3);
    check("R10 reset oe", {15'b0, dout_oe}, 16'h0000);

    // R5 R12: read while disabled, reset content
    do_read(0, 5, 1, "R5 R12 read disabled");

    // R4: write ignored while disabled, no busy status
    raw_write(0, 5, 16'h003C);
    close_frame();
    cs = 1'b1; tick(2);
    check("R4 no busy when disabled", {15'b0, dout_oe}, 16'h0000);
    close_frame();
    do_read(0, 5, 1, "R4 unchanged");

    // R8 R9: exact status timing
    do_pen(0);
    raw_write(0, 5, 16'h003C);
    ref_store(0, 5, 16'h003C);
    close_frame();
    check("R10 oe cs low", {15'b0, dout_oe}, 16'h0000);
    cs = 1'b1; tick(2);
    check("R8 busy status", {14'b0, dout_oe, dout}, 16'h0002);
    tick(PROG - 6);
    check("R8 last busy cycle", {14'b0, dout_oe, dout}, 16'h0002);
    tick(1);
    check("R8 ready", {14'b0, dout_oe, dout}, 16'h0003);
    close_frame();
    cs = 1'b1; tick(2);
    check("R9 no status after done", {15'b0, dout_oe}, 16'h0000);
    close_frame();
    do_read(0, 5, 1, "R1 R2 read back");

    // R12 word mapping, R3 sequential
    do_write(1, 3, 16'hA55A);
    do_read(0, 6, 2, "R12 byte view");
    do_read(1, 3, 1, "R12 word view");
    do_write(0, 255, 16'h0077);
    do_read(0, 255, 2, "R3 wrap x8");
    do_write(1, 127, 16'hBEEF);
    do_read(1, 127, 2, "R3 wrap x16");

    // R6 erase and overwrite
    do_erase(0, 6);
    do_read(0, 6, 1, "R6 erase");
    do_write(0, 7, 16'h000F);
    do_read(0, 7, 1, "R6 overwrite");

    // R11 instruction during busy
    raw_write(0, 10, 16'h0011);
    close_frame();
    ref_store(0, 10, 16'h0011);
    raw_write(0, 11, 16'h0022);
    close_frame();
    tick(PROG + 4);
    do_read(0, 10, 2, "R11 busy ignore");

    // R4 disable again
    do_pdis(1);
    do_write(1, 20, 16'h1234);
    do_read(1, 20, 1, "R4 disabled again");
    do_pen(1);

    // R7 R6 bulk
    do_fila(1, 16'h1234);
    do_read(1, 0, 3, "R7 fill x16");
    do_read(0, 200, 2, "R7 fill bytes");
    do_fila(0, 16'h00C3);
    do_read(0, 100, 2, "R7 fill x8");
    do_clra(0);
    do_read(1, 50, 2, "R6 clear all");

    // random mix
    for (int it = 0; it < 60; it++) begin
      bit o;
      int a;
      o = 1'($urandom_range(0, 1));
      a = o ? $urandom_range(0, DEPTH/2 - 1) : $urandom_range(0, DEPTH - 1);
      case ($urandom_range(0, 5))
        0, 1: do_write(o, a, 16'($urandom()));
        2:    do_erase(o, a);
        3:    do_read(o, a, $urandom_range(1, 3), "R2 R3 random read");
        4:    do_pen(o);
        default: if ($urandom_range(0, 3) == 0) do_pdis(o); else do_pen(o);
      endcase
    end
    do_read(0, 0, 4, "R2 final read");

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule